// File: doc/BRIEF.md
# Streaming Grayscale Edge Detector with Threshold

This block watches a grayscale pixel stream that travels with five control flags (line start, line end, frame start, frame end, pixel valid) and emits a one-bit edge stream with its own copy of those flags. For each active pixel it forms a 3x3 window and applies the two fixed Sobel kernels to get a horizontal gradient Gx and a vertical gradient Gy. The pixel is flagged as an edge when Gx*Gx + Gy*Gy is strictly greater than the square of a programmable threshold, so no square root is needed. Missing neighbours at the frame edges are filled in by repeating the nearest row or column of the active frame.

The two previous rows are held in two circular line delays written so that block RAM can be inferred. Each delay is one line period long, counted in clock cycles including blanking. The input stream must therefore keep a constant line period of `H_TOT` cycles within a frame, with valid pixels contiguous inside each line. There must be at least one blank cycle after each line and at least one fully blank line after each frame. The threshold is a 9-bit register loaded through a write strobe. Its value can never exceed 256, which keeps the edge count monotone in the threshold.

Top module: `pix_edge_thresh`

## Requirements
- R1: While reset is high and on the first cycle after it, all six outputs are 0 and the stored threshold is 7. With no threshold write, a horizontal step of height 2 (Gx = 8) is flagged as an edge.
- R2: Each of the five output control flags equals the matching input flag sampled exactly `H_TOT + 4` clock cycles earlier.
- R3: A threshold write of a value above 256 stores 256. After writing 300 or 511, a horizontal step of height 65 (Gx = 260) is still flagged. After writing 256, a step of height 64 (Gx = 256) is not flagged.
- R4: For an output pixel with valid high, `edge_o` is 1 exactly when Gx*Gx + Gy*Gy > T*T. T is the stored threshold. Gx is (right column weighted 1,2,1) minus (left column weighted 1,2,1), and Gy is (bottom row weighted 1,2,1) minus (top row weighted 1,2,1). Equality is not an edge.
- R5: Neighbours outside the active frame take the value of the nearest pixel inside it, in both rows and columns. A frame of one constant value gives no edge anywhere, even with a threshold of 0.
- R6: On every output cycle with `vld_o` low, `edge_o` is 0.
- R7: For one fixed input frame, raising the threshold never raises the number of pixels flagged as edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pix_i | input | PIX_W | Grayscale input pixel |
| sol_i | input | 1 | First pixel of a line |
| eol_i | input | 1 | Last pixel of a line |
| sof_i | input | 1 | First pixel of a frame |
| eof_i | input | 1 | Last pixel of a frame |
| vld_i | input | 1 | Input pixel is active |
| thr_wr_i | input | 1 | Load the threshold register |
| thr_i | input | THR_W | Threshold value to load (clamped to THR_MAX) |
| edge_o | output | 1 | 1 when the delayed pixel is an edge |
| sol_o | output | 1 | Delayed line start |
| eol_o | output | 1 | Delayed line end |
| sof_o | output | 1 | Delayed frame start |
| eof_o | output | 1 | Delayed frame end |
| vld_o | output | 1 | Delayed pixel valid |

## Verification
The bench builds the block with 8-bit pixels, a 9-bit threshold and a 12-cycle line period that carries an 8-pixel active line. Frames are 5 rows high with two blank lines after them. At this size every pixel of every frame is compared against an arithmetic Sobel model, and each corner and edge position is hit many times. The control flags are compared on every cycle against a history of the input. Directed frames (steps sized exactly at the threshold, constant fields, a single bright corner, stripes) and threshold sweeps from 0 to 256 and beyond reach the equality boundary, the clamp and the monotone ordering within a few thousand cycles.

// File: rtl/pedge_pkg.sv
package pedge_pkg;

  // Control flags that travel with each pixel, in a fixed bit order.
  typedef struct packed {
    logic sol;
    logic eol;
    logic sof;
    logic eof;
    logic vld;
  } strm_ctl_t;

  localparam int CTL_W = 5;

endpackage

// File: rtl/line_delay.sv
// Fixed delay built as a circular buffer. The memory has no reset so that
// it can map to block RAM. The output stays zero until every slot has
// been written once.
module line_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 15
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  rd_raw;
  logic [AW-1:0] ptr;
  logic          primed;
  logic          rd_ok;

  // Read-before-write on one address: block RAM friendly.
  always_ff @(posedge clk_i) begin
    rd_raw   <= mem[ptr];
    mem[ptr] <= din_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ptr    <= '0;
      primed <= 1'b0;
      rd_ok  <= 1'b0;
    end else begin
      rd_ok <= primed;
      if (ptr == AW'(DEPTH - 1)) begin
        ptr    <= '0;
        primed <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  assign dout_o = rd_ok ? rd_raw : '0;

endmodule

// File: rtl/sobel_grad.sv
// Horizontal border fill plus the two 3x3 Sobel sums, registered.
// Column index 0 is the oldest (left), 2 the newest (right).
module sobel_grad #(
  parameter int PIX_W = 8,
  localparam int GW   = PIX_W + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [PIX_W-1:0]     top_i [3],
  input  logic [PIX_W-1:0]     mid_i [3],
  input  logic [PIX_W-1:0]     bot_i [3],
  input  logic                 lv_i,
  input  logic                 rv_i,
  output logic signed [GW-1:0] gx_o,
  output logic signed [GW-1:0] gy_o
);

  function automatic logic signed [GW-1:0] ext(input logic [PIX_W-1:0] p);
    return $signed({{(GW-PIX_W){1'b0}}, p});
  endfunction

  logic [PIX_W-1:0] lt, lm, lb, rt, rm, rb;
  logic signed [GW-1:0] col_l, col_r, row_t, row_b;

  // A column outside the active line is replaced by the centre column.
  always_comb begin
    lt = lv_i ? top_i[0] : top_i[1];
    lm = lv_i ? mid_i[0] : mid_i[1];
    lb = lv_i ? bot_i[0] : bot_i[1];
    rt = rv_i ? top_i[2] : top_i[1];
    rm = rv_i ? mid_i[2] : mid_i[1];
    rb = rv_i ? bot_i[2] : bot_i[1];
  end

  always_comb begin
    col_l = ext(lt) + (ext(lm) <<< 1) + ext(lb);
    col_r = ext(rt) + (ext(rm) <<< 1) + ext(rb);
    row_t = ext(lt) + (ext(top_i[1]) <<< 1) + ext(rt);
    row_b = ext(lb) + (ext(bot_i[1]) <<< 1) + ext(rb);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      gx_o <= '0;
      gy_o <= '0;
    end else begin
      gx_o <= col_r - col_l;
      gy_o <= row_b - row_t;
    end
  end

endmodule

// File: rtl/thr_reg.sv
// Threshold register. Any write above the limit saturates to the limit.
module thr_reg #(
  parameter int THR_W   = 9,
  parameter int THR_MAX = 256,
  parameter int THR_RST = 7
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_i,
  input  logic [THR_W-1:0] data_i,
  output logic [THR_W-1:0] thr_o
);

  localparam logic [THR_W-1:0] LIM = THR_W'(THR_MAX);
  localparam logic [THR_W-1:0] INI = THR_W'(THR_RST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      thr_o <= INI;
    end else if (wr_i) begin
      thr_o <= (data_i > LIM) ? LIM : data_i;
    end
  end

endmodule

// File: rtl/pix_edge_thresh.sv
module pix_edge_thresh
  import pedge_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int H_TOT   = 16,
  parameter int THR_W   = 9,
  parameter int THR_MAX = 256,
  parameter int THR_RST = 7
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             sol_i,
  input  logic             eol_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic             vld_i,
  input  logic             thr_wr_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             edge_o,
  output logic             sol_o,
  output logic             eol_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic             vld_o
);

  localparam int LB_DEPTH = H_TOT - 1;
  localparam int GW       = PIX_W + 3;
  localparam int SW       = 2 * GW;
  localparam int MW       = SW + 1;
  localparam int TSW      = 2 * THR_W;
  localparam int CW       = (MW > TSW) ? MW : TSW;
  localparam int NCOL     = 3;

  // Input register.
  strm_ctl_t        ctl_in, ctl_r0;
  logic [PIX_W-1:0] pix_r0;

  assign ctl_in = {sol_i, eol_i, sof_i, eof_i, vld_i};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctl_r0 <= '0;
      pix_r0 <= '0;
    end else begin
      ctl_r0 <= ctl_in;
      pix_r0 <= pix_i;
    end
  end

  // Two line delays: one line period each, so the three taps line up
  // vertically on the same column.
  logic [PIX_W+CTL_W-1:0] near_q;
  logic [PIX_W:0]         far_q;
  strm_ctl_t              ctl_mid;
  logic [PIX_W-1:0]       pix_mid, pix_top;
  logic                   vld_top;

  line_delay #(.W(PIX_W + CTL_W), .DEPTH(LB_DEPTH)) u_lb_near (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .din_i  ({ctl_r0, pix_r0}),
    .dout_o (near_q)
  );

  assign {ctl_mid, pix_mid} = near_q;

  line_delay #(.W(PIX_W + 1), .DEPTH(LB_DEPTH)) u_lb_far (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .din_i  ({ctl_mid.vld, pix_mid}),
    .dout_o (far_q)
  );

  assign {vld_top, pix_top} = far_q;

  // Vertical border fill: a row outside the frame repeats the centre row.
  logic [PIX_W-1:0] top_v, bot_v;

  always_comb begin
    top_v = vld_top    ? pix_top : pix_mid;
    bot_v = ctl_r0.vld ? pix_r0  : pix_mid;
  end

  // Three-column window shift.
  logic [PIX_W-1:0] col_t [NCOL];
  logic [PIX_W-1:0] col_m [NCOL];
  logic [PIX_W-1:0] col_b [NCOL];
  strm_ctl_t        col_c [NCOL];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < NCOL; i++) begin
        col_t[i] <= '0;
        col_m[i] <= '0;
        col_b[i] <= '0;
        col_c[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCOL - 1; i++) begin
        col_t[i] <= col_t[i+1];
        col_m[i] <= col_m[i+1];
        col_b[i] <= col_b[i+1];
        col_c[i] <= col_c[i+1];
      end
      col_t[NCOL-1] <= top_v;
      col_m[NCOL-1] <= pix_mid;
      col_b[NCOL-1] <= bot_v;
      col_c[NCOL-1] <= ctl_mid;
    end
  end

  // Gradient stage.
  logic signed [GW-1:0] gx_q, gy_q;
  strm_ctl_t            ctl_g;

  sobel_grad #(.PIX_W(PIX_W)) u_grad (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .top_i (col_t),
    .mid_i (col_m),
    .bot_i (col_b),
    .lv_i  (col_c[0].vld),
    .rv_i  (col_c[NCOL-1].vld),
    .gx_o  (gx_q),
    .gy_o  (gy_q)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) ctl_g <= '0;
    else       ctl_g <= col_c[1];
  end

  // Threshold register.
  logic [THR_W-1:0] thr_q;

  thr_reg #(.THR_W(THR_W), .THR_MAX(THR_MAX), .THR_RST(THR_RST)) u_thr (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .wr_i   (thr_wr_i),
    .data_i (thr_i),
    .thr_o  (thr_q)
  );

  // Squared magnitude against squared threshold.
  logic signed [SW-1:0] gx_e, gy_e, gx_sq, gy_sq;
  logic [CW-1:0]        mag, thr_sq;
  logic                 over;

  always_comb begin
    gx_e   = SW'(gx_q);
    gy_e   = SW'(gy_q);
    gx_sq  = gx_e * gx_e;
    gy_sq  = gy_e * gy_e;
    mag    = CW'(unsigned'(gx_sq)) + CW'(unsigned'(gy_sq));
    thr_sq = CW'(thr_q) * CW'(thr_q);
    over   = mag > thr_sq;
  end

  // Registered outputs.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      edge_o <= 1'b0;
      sol_o  <= 1'b0;
      eol_o  <= 1'b0;
      sof_o  <= 1'b0;
      eof_o  <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      edge_o <= ctl_g.vld && over;
      sol_o  <= ctl_g.sol;
      eol_o  <= ctl_g.eol;
      sof_o  <= ctl_g.sof;
      eof_o  <= ctl_g.eof;
      vld_o  <= ctl_g.vld;
    end
  end

endmodule

// File: rtl/pix_edge_thresh_chk.sv
module pix_edge_thresh_chk #(
  parameter int THR_W   = 9,
  parameter int THR_MAX = 256,
  parameter int THR_RST = 7
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             thr_wr_i,
  input logic [THR_W-1:0] thr_i,
  input logic [THR_W-1:0] thr_q,
  input logic [4:0]       mid_ctl,
  input logic [4:0]       out_ctl,
  input logic             edge_o,
  input logic             vld_o
);

  // R1: first cycle after reset shows the default threshold and idle outputs.
  a_r1_reset_state: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (thr_q == THR_W'(THR_RST) && !vld_o && !edge_o));

  // R2: output flags follow the centre line-delay tap four registers later.
  a_r2_ctl_delay: assert property (@(posedge clk_i) disable iff (rst_i)
    out_ctl == $past(mid_ctl, 4));

  // R3: stored threshold never leaves its range.
  a_r3_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
    thr_q <= THR_W'(THR_MAX));

  // R3: an oversize write saturates.
  a_r3_clamp: assert property (@(posedge clk_i) disable iff (rst_i)
    (thr_wr_i && thr_i > THR_W'(THR_MAX)) |=> thr_q == THR_W'(THR_MAX));

  // R6: no edge flag on an idle output cycle.
  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    !vld_o |-> !edge_o);

endmodule

bind pix_edge_thresh pix_edge_thresh_chk #(
  .THR_W   (THR_W),
  .THR_MAX (THR_MAX),
  .THR_RST (THR_RST)
) i_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .thr_wr_i (thr_wr_i),
  .thr_i    (thr_i),
  .thr_q    (thr_q),
  .mid_ctl  (ctl_mid),
  .out_ctl  ({sol_o, eol_o, sof_o, eof_o, vld_o}),
  .edge_o   (edge_o),
  .vld_o    (vld_o)
);

// File: tb/test_pix_edge_thresh.sv
`timescale 1ns/1ps
module test_pix_edge_thresh;

  localparam int PW   = 8;
  localparam int TW   = 9;
  localparam int HT   = 12;
  localparam int COLS = 8;
  localparam int ROWS = 5;
  localparam int VB   = 2;
  localparam int LAT  = HT + 4;
  localparam int HD   = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] pix = '0;
  logic          sol = 1'b0, eol = 1'b0, sof = 1'b0, eof = 1'b0, vld = 1'b0;
  logic          thr_wr = 1'b0;
  logic [TW-1:0] thr_d = '0;
  logic          edge_q, sol_q, eol_q, sof_q, eof_q, vld_q;

  always #2.5 clk = ~clk;

  pix_edge_thresh #(.PIX_W(PW), .H_TOT(HT), .THR_W(TW)) i_pix_edge_thresh (
    .clk_i (clk), .rst_i (rst), .pix_i (pix),
    .sol_i (sol), .eol_i (eol), .sof_i (sof), .eof_i (eof), .vld_i (vld),
    .thr_wr_i (thr_wr), .thr_i (thr_d),
    .edge_o (edge_q), .sol_o (sol_q), .eol_o (eol_q),
    .sof_o (sof_q), .eof_o (eof_q), .vld_o (vld_q)
  );

  int   img [ROWS][COLS];
  int   total = 0, bad = 0;
  int   cyc = 0;
  int   edge_cnt = 0, exp_cnt = 0;
  int   cur_thr = 7;
  bit   done = 0;
  bit   drv_exp = 0;
  logic [4:0] hist_ctl [HD];
  bit         hist_exp [HD];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pv(input int r, input int c);
    int rr, cc;
    rr = (r < 0) ? 0 : ((r > ROWS-1) ? ROWS-1 : r);
    cc = (c < 0) ? 0 : ((c > COLS-1) ? COLS-1 : c);
    return img[rr][cc];
  endfunction

  function automatic bit golden(input int r, input int c, input int t);
    int gx, gy;
    gx = (pv(r-1,c+1) + 2*pv(r,c+1) + pv(r+1,c+1))
       - (pv(r-1,c-1) + 2*pv(r,c-1) + pv(r+1,c-1));
    gy = (pv(r+1,c-1) + 2*pv(r+1,c) + pv(r+1,c+1))
       - (pv(r-1,c-1) + 2*pv(r-1,c) + pv(r-1,c+1));
    return (gx*gx + gy*gy) > (t*t);
  endfunction

  // Record what the design samples at each rising edge.
  always @(posedge clk) begin
    hist_ctl[cyc % HD] = {sol, eol, sof, eof, vld};
    hist_exp[cyc % HD] = drv_exp;
    cyc++;
  end

  // Compare outputs between edges against the input LAT cycles back.
  always @(negedge clk) begin
    int idx;
    if (!rst && !done && cyc >= LAT + 1) begin
      idx = (cyc - 1 - LAT) % HD;
      chk({sol_q, eol_q, sof_q, eof_q, vld_q} == hist_ctl[idx], "R2",
          "control flags", int'({sol_q, eol_q, sof_q, eof_q, vld_q}),
          int'(hist_ctl[idx]));
      if (hist_ctl[idx][0])
        chk(edge_q == hist_exp[idx], "R4", "edge pixel",
            int'(edge_q), int'(hist_exp[idx]));
      else
        chk(edge_q == 1'b0, "R6", "edge on idle cycle", int'(edge_q), 0);
      if (edge_q && vld_q) edge_cnt++;
    end
  end

  task automatic set_thr(input int v);
    @(negedge clk);
    thr_wr  = 1'b1;
    thr_d   = TW'(v);
    cur_thr = (v > 256) ? 256 : v;
    @(negedge clk);
    thr_wr  = 1'b0;
  endtask

  task automatic send_frame();
    bit act;
    edge_cnt = 0;
    exp_cnt  = 0;
    for (int r = 0; r < ROWS + VB; r++) begin
      for (int c = 0; c < HT; c++) begin
        @(negedge clk);
        act     = (r < ROWS) && (c < COLS);
        vld     = act;
        sol     = act && (c == 0);
        eol     = act && (c == COLS-1);
        sof     = act && (r == 0) && (c == 0);
        eof     = act && (r == ROWS-1) && (c == COLS-1);
        pix     = act ? PW'(img[r][c]) : '0;
        drv_exp = act ? golden(r, c, cur_thr) : 1'b0;
        exp_cnt += int'(drv_exp);
      end
    end
    @(negedge clk);
    {vld, sol, eol, sof, eof} = '0;
    pix = '0;
    drv_exp = 1'b0;
  endtask

  task automatic fill_step(input int a, input int b, input int col);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        img[r][c] = (c < col) ? a : b;
  endtask

  task automatic fill_const(input int v);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        img[r][c] = v;
  endtask

  task automatic fill_rows(input int a, input int b, input int row);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        img[r][c] = (r < row) ? a : b;
  endtask

  task automatic fill_rand();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        img[r][c] = int'($urandom_range(0, 255));
  endtask

  initial begin
    int prev;
    // R1: outputs idle during reset.
    repeat (5) @(negedge clk);
    chk({edge_q, sol_q, eol_q, sof_q, eof_q, vld_q} == '0, "R1",
        "outputs in reset", int'({edge_q, sol_q, eol_q, sof_q, eof_q, vld_q}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({edge_q, sol_q, eol_q, sof_q, eof_q, vld_q} == '0, "R1",
        "outputs after reset", int'({edge_q, sol_q, eol_q, sof_q, eof_q, vld_q}), 0);

    // R1: default threshold 7 flags a step of 2 (Gx = 8).
    fill_step(100, 102, 4);
    send_frame();
    chk(edge_cnt == 2*ROWS, "R1", "edges at default threshold", edge_cnt, 2*ROWS);

    // R4: threshold 8 with Gx = 8 is equality, not an edge.
    set_thr(8);
    send_frame();
    chk(edge_cnt == 0, "R4", "edges at equality", edge_cnt, 0);

    // R5: constant frame gives no edge even at threshold 0.
    set_thr(0);
    fill_const(100);
    send_frame();
    chk(edge_cnt == 0, "R5", "edges in constant frame", edge_cnt, 0);

    // R5: single bright corner pixel, checked per pixel.
    fill_const(0);
    img[0][0] = 200;
    send_frame();
    chk(edge_cnt == exp_cnt, "R5", "corner pixel edge count", edge_cnt, exp_cnt);
    fill_const(0);
    img[ROWS-1][COLS-1] = 150;
    send_frame();
    chk(edge_cnt == exp_cnt, "R5", "far corner edge count", edge_cnt, exp_cnt);

    // R4: vertical gradient from row stripes.
    set_thr(7);
    fill_rows(10, 90, 2);
    send_frame();
    chk(edge_cnt == exp_cnt, "R4", "row stripe edge count", edge_cnt, exp_cnt);

    // R7: threshold sweep over fixed random frames.
    for (int f = 0; f < 2; f++) begin
      fill_rand();
      prev = ROWS * COLS + 1;
      for (int k = 0; k < 6; k++) begin
        case (k)
          0: set_thr(0);
          1: set_thr(20);
          2: set_thr(60);
          3: set_thr(120);
          4: set_thr(200);
          default: set_thr(256);
        endcase
        send_frame();
        chk(edge_cnt == exp_cnt, "R4", "random frame edge count", edge_cnt, exp_cnt);
        chk(edge_cnt <= prev, "R7", "edge count not rising", edge_cnt, prev);
        prev = edge_cnt;
      end
    end

    // R3: oversize writes saturate at 256.
    set_thr(300);
    fill_step(100, 165, 3);
    send_frame();
    chk(edge_cnt == 2*ROWS, "R3", "edges after writing 300", edge_cnt, 2*ROWS);
    set_thr(511);
    send_frame();
    chk(edge_cnt == 2*ROWS, "R3", "edges after writing 511", edge_cnt, 2*ROWS);
    set_thr(256);
    fill_step(100, 164, 5);
    send_frame();
    chk(edge_cnt == 0, "R3", "edges at 256 with Gx 256", edge_cnt, 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule